// File: doc/BRIEF.md
# Hybrid Overlap-Add with Frequency Inversion

This block sits after the inverse transform stage of a subband audio decoder. For each subband of each granule it receives a stream of 36 time-domain values. Long and short windows arrive in the same order, because the three short transforms are already merged into one 36-value block upstream. Values 0 to 17 are summed with the tail kept from the previous granule of the same subband and leave the block one cycle later. Values 18 to 35 replace that tail and produce nothing at the output.

Odd subbands see their odd output samples negated. This undoes the spectral flip of the analysis filter bank. The sum is clamped to the sample width before any negation, and negating the most negative code gives the most positive code. A restart input, or reset, empties every subband tail in one cycle, so the first granule after a restart passes through unchanged.

Top module: `imdct_overlap_add`

## Requirements
- R1: After reset `out_valid` is 0, and every stored tail reads as zero, so the first granule of a subband is output unmodified.
- R2: An accepted input with index 0..17 gives `out_valid`=1 exactly one cycle later, with `out_sb` and `out_idx` equal to that input's subband and index. Any other cycle has `out_valid`=0.
- R3: For an index k in 0..17 the output value is the input value plus the tail entry k that the previous granule of the same subband stored.
- R4: An input with index 18..35 writes tail entry (index-18) of its subband and produces no output.
- R5: The sum is clamped to the range -2^(W-1) to 2^(W-1)-1 (W=16: -32768 to 32767) instead of wrapping.
- R6: When both the subband number and the index are odd (bit 0 of each is 1), the clamped value is negated. Negating -32768 yields 32767.
- R7: Each of the 32 subbands keeps its own 18-entry tail. Traffic on one subband never alters another.
- R8: `restart`=1 clears every tail to zero. A sample accepted in the same cycle reads zero as its tail. If that sample has an index in 18..35, its write is kept.
- R9: An input with index 36..63 is discarded. It gives no output and changes no tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Clears all subband tails |
| in_valid | input | 1 | Input sample present |
| in_sb | input | 5 | Subband number of the input |
| in_idx | input | 6 | Position 0..35 within the 36-value block |
| in_data | input | 16 | Signed input value |
| out_valid | output | 1 | Output sample present |
| out_sb | output | 5 | Subband number of the output |
| out_idx | output | 5 | Time position 0..17 of the output |
| out_data | output | 16 | Signed, clamped, possibly negated output |

## Verification
Two functions can meet in one cycle: a restart that empties the tails, and a sample that reads or writes a tail. Directed steps put `restart` in the same cycle as a first-half read, which must see zero, and as a second-half write, which must survive and be read back by the next granule. Random traffic also raises `restart` at arbitrary points between subband blocks and inside them. A bench model applies the clear before the sample in each cycle and judges every output against that model.

// File: rtl/olap_pkg.sv
package olap_pkg;

    localparam int DEF_NUM_SB = 32;
    localparam int DEF_HALF   = 18;
    localparam int DEF_W      = 16;

    typedef enum logic [1:0] {
        SEG_OVERLAP = 2'd0,
        SEG_STORE   = 2'd1,
        SEG_DROP    = 2'd2
    } seg_e;

    function automatic seg_e classify(input int idx, input int half);
        if (idx < half)          return SEG_OVERLAP;
        else if (idx < 2 * half) return SEG_STORE;
        else                     return SEG_DROP;
    endfunction

endpackage

// File: rtl/olap_store.sv
module olap_store #(
    parameter int NUM_SB = 32,
    parameter int HALF   = 18,
    parameter int W      = 16,
    localparam int DEPTH  = NUM_SB * HALF,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int SB_W   = $clog2(NUM_SB),
    localparam int POS_W  = $clog2(HALF)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                rd_en,
    input  logic [SB_W-1:0]     rd_sb,
    input  logic [POS_W-1:0]    rd_pos,
    input  logic                wr_en,
    input  logic [SB_W-1:0]     wr_sb,
    input  logic [POS_W-1:0]    wr_pos,
    input  logic signed [W-1:0] wr_data,
    output logic signed [W-1:0] rd_data
);

    typedef struct packed {
        logic [DEPTH-1:0] filled;
        logic [W-1:0]     rdata;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    logic [ADDR_W-1:0] rd_addr, wr_addr;

    always_comb begin
        rd_addr = ADDR_W'(int'(rd_sb) * HALF + int'(rd_pos));
        wr_addr = ADDR_W'(int'(wr_sb) * HALF + int'(wr_pos));

        st_d = st_q;
        if (clr) begin
            st_d.filled = '0;
        end
        if (wr_en) begin
            st_d.filled[wr_addr] = 1'b1;
        end
        if (rd_en && !clr && st_q.filled[rd_addr]) begin
            st_d.rdata = mem[rd_addr];
        end else begin
            st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = st_q.rdata;

endmodule

// File: rtl/olap_combine.sv
module olap_combine #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] new_s,
    input  logic signed [W-1:0] old_s,
    input  logic                invert,
    output logic signed [W-1:0] result
);

    localparam logic signed [W:0] MAXV = {2'b00, {(W-1){1'b1}}};
    localparam logic signed [W:0] MINV = {2'b11, {(W-1){1'b0}}};

    logic signed [W:0] sum_w;
    logic signed [W:0] clamp_w;
    logic signed [W:0] neg_w;

    always_comb begin
        sum_w = {new_s[W-1], new_s} + {old_s[W-1], old_s};
        if (sum_w > MAXV)      clamp_w = MAXV;
        else if (sum_w < MINV) clamp_w = MINV;
        else                   clamp_w = sum_w;

        neg_w = -clamp_w;
        if (neg_w > MAXV) neg_w = MAXV;

        result = invert ? neg_w[W-1:0] : clamp_w[W-1:0];
    end

endmodule

// File: rtl/imdct_overlap_add.sv
module imdct_overlap_add #(
    parameter int NUM_SB = olap_pkg::DEF_NUM_SB,
    parameter int HALF   = olap_pkg::DEF_HALF,
    parameter int W      = olap_pkg::DEF_W,
    localparam int SB_W  = $clog2(NUM_SB),
    localparam int IDX_W = $clog2(2 * HALF),
    localparam int POS_W = $clog2(HALF)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                in_valid,
    input  logic [SB_W-1:0]     in_sb,
    input  logic [IDX_W-1:0]    in_idx,
    input  logic signed [W-1:0] in_data,
    output logic                out_valid,
    output logic [SB_W-1:0]     out_sb,
    output logic [POS_W-1:0]    out_idx,
    output logic signed [W-1:0] out_data
);

    import olap_pkg::*;

    typedef struct packed {
        logic             vld;
        logic [SB_W-1:0]  sb;
        logic [POS_W-1:0] pos;
        logic [W-1:0]     data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    seg_e                seg;
    logic                legal;
    logic                rd_en, wr_en;
    logic [POS_W-1:0]    rd_pos, wr_pos;
    logic signed [W-1:0] tail;
    logic signed [W-1:0] mixed;
    logic                flip;

    always_comb begin
        seg    = classify(int'(in_idx), HALF);
        legal  = in_valid && (int'(in_sb) < NUM_SB);
        rd_en  = legal && (seg == SEG_OVERLAP);
        wr_en  = legal && (seg == SEG_STORE);
        rd_pos = POS_W'(in_idx);
        wr_pos = POS_W'(int'(in_idx) - HALF);

        pipe_d      = pipe_q;
        pipe_d.vld  = rd_en;
        if (rd_en) begin
            pipe_d.sb   = in_sb;
            pipe_d.pos  = rd_pos;
            pipe_d.data = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    olap_store #(
        .NUM_SB (NUM_SB),
        .HALF   (HALF),
        .W      (W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .rd_en   (rd_en),
        .rd_sb   (in_sb),
        .rd_pos  (rd_pos),
        .wr_en   (wr_en),
        .wr_sb   (in_sb),
        .wr_pos  (wr_pos),
        .wr_data (in_data),
        .rd_data (tail)
    );

    assign flip = pipe_q.sb[0] & pipe_q.pos[0];

    olap_combine #(
        .W (W)
    ) u_combine (
        .new_s  (pipe_q.data),
        .old_s  (tail),
        .invert (flip),
        .result (mixed)
    );

    assign out_valid = pipe_q.vld;
    assign out_sb    = pipe_q.sb;
    assign out_idx   = pipe_q.pos;
    assign out_data  = pipe_q.vld ? mixed : '0;

endmodule

// File: rtl/olap_checker.sv
module olap_checker #(
    parameter int NUM_SB = 32,
    parameter int HALF   = 18,
    parameter int W      = 16,
    localparam int SB_W  = $clog2(NUM_SB),
    localparam int IDX_W = $clog2(2 * HALF),
    localparam int POS_W = $clog2(HALF)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                restart,
    input logic                in_valid,
    input logic [SB_W-1:0]     in_sb,
    input logic [IDX_W-1:0]    in_idx,
    input logic signed [W-1:0] in_data,
    input logic                out_valid,
    input logic [SB_W-1:0]     out_sb,
    input logic [POS_W-1:0]    out_idx,
    input logic signed [W-1:0] out_data
);

    logic first_half;
    logic minv;
    assign first_half = in_valid && (int'(in_idx) < HALF) && (int'(in_sb) < NUM_SB);
    assign minv       = (in_data == {1'b1, {(W-1){1'b0}}});

    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        first_half |=> out_valid); // R2

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !first_half |=> !out_valid); // R2

    AST_TAG_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        first_half |=> (out_sb == $past(in_sb)) && (int'(out_idx) == int'($past(in_idx)))); // R2

    AST_SECOND_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(in_idx) >= HALF) |=> !out_valid); // R4

    AST_RESTART_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && first_half && !(in_sb[0] && in_idx[0])) |=> out_data == $past(in_data)); // R8

    AST_RESTART_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && first_half && in_sb[0] && in_idx[0] && !minv) |=> out_data == -$past(in_data)); // R6

endmodule

bind imdct_overlap_add olap_checker #(
    .NUM_SB (NUM_SB),
    .HALF   (HALF),
    .W      (W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .in_valid  (in_valid),
    .in_sb     (in_sb),
    .in_idx    (in_idx),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_sb    (out_sb),
    .out_idx   (out_idx),
    .out_data  (out_data)
);

// File: tb/sim_imdct_overlap_add.sv
module sim_imdct_overlap_add;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_sb = '0;
    logic [5:0]  in_idx = '0;
    logic signed [15:0] in_data = '0;
    logic        out_valid;
    logic [4:0]  out_sb;
    logic [4:0]  out_idx;
    logic signed [15:0] out_data;

    int checks = 0;
    int fails  = 0;
    int model [32][18];

    always #2 clk = ~clk;

    imdct_overlap_add u0 (
        .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
        .in_sb(in_sb), .in_idx(in_idx), .in_data(in_data),
        .out_valid(out_valid), .out_sb(out_sb), .out_idx(out_idx), .out_data(out_data)
    );

    function automatic int clamp16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int predict(input int sb, input int idx, input int data);
        int s;
        s = clamp16(data + model[sb][idx]);
        if ((sb % 2 == 1) && (idx % 2 == 1)) s = clamp16(-s);
        return s;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic step(input bit v, input int sb, input int idx, input int data,
                        input bit rs, input string tag);
        bit ev;
        int ed;
        ed = 0;
        in_valid = v; in_sb = 5'(sb); in_idx = 6'(idx); in_data = 16'(data); restart = rs;
        if (rs) begin
            for (int a = 0; a < 32; a++)
                for (int b = 0; b < 18; b++) model[a][b] = 0;
        end
        ev = v && (idx < 18);
        if (ev) ed = predict(sb, idx, data);
        if (v && idx >= 18 && idx < 36) model[sb][idx-18] = data;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; restart = 1'b0;
        chk(out_valid == ev, tag, int'(out_valid), int'(ev));
        if (ev) begin
            chk(int'(out_data) == ed, tag, int'(out_data), ed);
            chk(int'(out_sb) == sb && int'(out_idx) == idx, tag,
                int'(out_sb) * 100 + int'(out_idx), sb * 100 + idx);
        end
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(7));
        for (int a = 0; a < 32; a++)
            for (int b = 0; b < 18; b++) model[a][b] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);

        // R1: first granule passes through (odd sb 3 shows inversion too)
        for (int k = 0; k < 18; k++) step(1, 3, k, 100 + k, 0, "R1");
        // R4: second half gives no output and fills tail
        for (int k = 18; k < 36; k++) step(1, 3, k, 1000 + k, 0, "R4");
        // R3: next granule adds the tail
        for (int k = 0; k < 18; k++) step(1, 3, k, -7 * k, 0, "R3");

        // R5: clamp both directions on even subband 2
        step(1, 2, 18, 30000, 0, "R5");
        step(1, 2, 19, -30000, 0, "R5");
        step(1, 2, 0, 10000, 0, "R5");
        step(1, 2, 1, -10000, 0, "R5");

        // R6: clamp to min then negate on odd subband, odd index
        step(1, 5, 21, -30000, 0, "R6");
        step(1, 5, 3, -10000, 0, "R6");
        step(1, 5, 20, 40, 0, "R6");
        step(1, 5, 2, 1, 0, "R6");

        // R7: neighbours kept apart
        step(1, 7, 18, 1234, 0, "R7");
        step(1, 8, 18, -55, 0, "R7");
        step(1, 8, 0, 0, 0, "R7");
        step(1, 7, 0, 0, 0, "R7");

        // R9: index out of range ignored
        step(1, 9, 22, 77, 0, "R9");
        step(1, 9, 40, 999, 0, "R9");
        step(1, 9, 63, -999, 0, "R9");
        step(1, 9, 4, 0, 0, "R9");

        // R8: restart with same-cycle read and same-cycle write
        step(1, 10, 20, 500, 0, "R8");
        step(1, 11, 19, 600, 0, "R8");
        step(1, 10, 2, 7, 1, "R8");
        step(1, 11, 1, 9, 0, "R8");
        step(1, 12, 23, 321, 1, "R8");
        step(1, 12, 5, 1, 0, "R8");
        step(0, 0, 0, 0, 1, "R8");
        step(1, 12, 5, 2, 0, "R8");

        // random traffic, blocks interleaved with gaps and restarts
        for (int g = 0; g < 400; g++) begin
            int sb;
            sb = int'($urandom_range(0, 31));
            for (int k = 0; k < 36; k++) begin
                int d;
                bit rs;
                d  = int'($urandom_range(0, 65535)) - 32768;
                if ($urandom_range(0, 3) != 0) d = d / 3;
                rs = ($urandom_range(0, 199) == 0);
                if ($urandom_range(0, 7) == 0) step(0, 0, 0, 0, 0, "R2");
                if ($urandom_range(0, 31) == 0)
                    step(1, sb, int'($urandom_range(36, 63)), d, 0, "R9");
                step(1, sb, k, d, rs, rs ? "R8" : "R3");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule